// File: doc/BRIEF.md
# Enhanced Clock Victim Selector

This block picks the physical frame to give up when a new page must be brought in. A circular hand walks a ring of `NUM_FRAMES` frames in ascending index order and wraps from the last frame back to frame 0. The block keeps one use bit per frame. The use bit is set whenever the address translator reports an access to that frame. Occupancy and dirty state arrive as vectors from outside. On a request the block returns a frame index and a flag that says whether the frame must be written back before reuse. A one-cycle done pulse marks the result.

A mode input chooses between two policies. In the basic policy the hand gives a second chance to every recently used frame. In the ranked policy the hand sorts frames into four classes by (use, dirty) and takes the first frame of the best class that has a member. A free frame always wins over evicting a resident page, and it is returned without any scan. The block examines one frame per clock. The bound on a scan is a fixed number of ring sweeps.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset `busy` and `done` are low, every use bit is clear, and the hand points at frame 0.
- R2: A cycle with `acc_valid` high sets the use bit of frame `acc_frame`. If the hand clears that same bit in the same cycle, the set wins.
- R3: If any frame has its `occ` bit at 0 when an idle block sees `req`, `done` rises on the next cycle and `busy` never rises. `victim` is the first unoccupied frame at or after the hand, with wraparound, and `victim_dirty` is 0.
- R4: With `mode_enh`=0 (basic policy), each frame the hand examines with its use bit set has that bit cleared and is skipped. The first frame with a clear use bit is the victim, and `victim_dirty` carries that frame's `dirty` bit.
- R5: With `mode_enh`=1 (ranked policy), the preference from best to worst is (use,dirty) = (0,0), (0,1), (1,0), (1,1). The victim is the first frame from the hand that belongs to the best class with a member.
- R6: A ranked scan alternates between two sweeps. The first sweep looks for (0,0) and leaves all bits alone. The second sweep takes any frame with a clear use bit and clears the use bit of every frame it passes. When every frame is used and dirty, the frame at the hand is taken after 3*NUM_FRAMES+1 examined frames.
- R7: After any selection the hand moves to the frame after the victim, wrapping from NUM_FRAMES-1 to 0.
- R8: A scan examines one frame per cycle. `busy` is high for exactly the number of examined frames, and never for more than 4*NUM_FRAMES cycles. `done` is a single-cycle pulse with `busy` low.
- R9: A `req` that arrives while `busy` is high is ignored, and it yields no further `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_enh | input | 1 | 0 = basic policy, 1 = ranked (use, dirty) policy; sampled at request |
| req | input | 1 | Start a victim selection (idle only) |
| acc_valid | input | 1 | An access to frame `acc_frame` occurred |
| acc_frame | input | IDX_W | Frame index of the reported access |
| occ | input | NUM_FRAMES | Per-frame occupied flag |
| dirty | input | NUM_FRAMES | Per-frame modified flag |
| busy | output | 1 | A ring scan is in progress |
| done | output | 1 | One-cycle pulse: `victim` and `victim_dirty` are valid |
| victim | output | IDX_W | Chosen frame index |
| victim_dirty | output | 1 | Chosen frame needs writeback |

## Verification
If the hand or the phase register drifts, the fault appears at the next `done` as a wrong `victim`. It also shows as a `busy` length that differs from the count of frames the policy should examine. Cycle-exact `busy` lengths therefore expose a sweep that ends early or late, within the same request. If a use bit is cleared at the wrong moment, the damage shows up one request later, when the next victim comes out different. For that reason, back-to-back requests are checked as well as single ones.

// File: rtl/cvs_pkg.sv
`timescale 1ns/1ps
package cvs_pkg;
   typedef enum logic [1:0] {
      PH_SIMPLE = 2'd0,
      PH_LOOK00 = 2'd1,
      PH_LOOK01 = 2'd2
   } phase_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } state_e;
endpackage

// File: rtl/cvs_use_bits.sv
`timescale 1ns/1ps
module cvs_use_bits #(
   parameter int NUM_FRAMES = 8,
   localparam int IDX_W = $clog2(NUM_FRAMES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  set_en,
   input  logic [IDX_W-1:0]      set_idx,
   input  logic                  clr_en,
   input  logic [IDX_W-1:0]      clr_idx,
   output logic [NUM_FRAMES-1:0] use_q
);
   for (genvar gi = 0; gi < NUM_FRAMES; gi++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            use_q[gi] <= 1'b0;
         else if (set_en && set_idx == IDX_W'(gi))
            use_q[gi] <= 1'b1;
         else if (clr_en && clr_idx == IDX_W'(gi))
            use_q[gi] <= 1'b0;
      end
   end

   // R2: an access always leaves the use bit set
   p_access_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> use_q[$past(set_idx)]);
endmodule

// File: rtl/cvs_free_pick.sv
`timescale 1ns/1ps
module cvs_free_pick #(
   parameter int NUM_FRAMES = 8,
   localparam int IDX_W = $clog2(NUM_FRAMES)
) (
   input  logic [IDX_W-1:0]      hand,
   input  logic [NUM_FRAMES-1:0] occ,
   output logic                  any_free,
   output logic [IDX_W-1:0]      free_idx
);
   int pos;
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      pos      = 0;
      // walk from the far end so that the nearest free frame wins last
      for (int k = NUM_FRAMES - 1; k >= 0; k--) begin
         pos = int'(hand) + k;
         if (pos >= NUM_FRAMES) pos = pos - NUM_FRAMES;
         if (!occ[IDX_W'(pos)]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(pos);
         end
      end
   end
endmodule

// File: rtl/cvs_scan_ctrl.sv
`timescale 1ns/1ps
module cvs_scan_ctrl
   import cvs_pkg::*;
#(
   parameter int NUM_FRAMES = 8,
   localparam int IDX_W = $clog2(NUM_FRAMES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic                  mode_enh,
   input  logic                  any_free,
   input  logic [IDX_W-1:0]      free_idx,
   input  logic [NUM_FRAMES-1:0] use_q,
   input  logic [NUM_FRAMES-1:0] dirty,
   output logic                  clr_en,
   output logic [IDX_W-1:0]      clr_idx,
   output logic [IDX_W-1:0]      hand,
   output phase_e                phase,
   output logic                  busy,
   output logic                  done,
   output logic [IDX_W-1:0]      victim,
   output logic                  victim_dirty
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

   state_e           st_q;
   phase_e           ph_q;
   logic [IDX_W-1:0] hand_q, cnt_q, victim_q;
   logic             done_q, vd_q;
   logic             cur_use, cur_dirty, hit, sweep_end;

   function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
      return (i == LAST_IDX) ? '0 : i + 1'b1;
   endfunction

   assign cur_use   = use_q[hand_q];
   assign cur_dirty = dirty[hand_q];
   assign sweep_end = (cnt_q == LAST_IDX);

   always_comb begin
      unique case (ph_q)
         PH_SIMPLE: hit = !cur_use;
         PH_LOOK00: hit = !cur_use && !cur_dirty;
         PH_LOOK01: hit = !cur_use;
         default:   hit = 1'b0;
      endcase
   end

   assign clr_en  = (st_q == ST_SCAN) && cur_use && (ph_q != PH_LOOK00);
   assign clr_idx = hand_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         ph_q     <= PH_SIMPLE;
         hand_q   <= '0;
         cnt_q    <= '0;
         victim_q <= '0;
         vd_q     <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req) begin
                  if (any_free) begin
                     done_q   <= 1'b1;
                     victim_q <= free_idx;
                     vd_q     <= 1'b0;
                     hand_q   <= step(free_idx);
                  end else begin
                     st_q  <= ST_SCAN;
                     ph_q  <= mode_enh ? PH_LOOK00 : PH_SIMPLE;
                     cnt_q <= '0;
                  end
               end
            end
            ST_SCAN: begin
               if (hit) begin
                  st_q     <= ST_IDLE;
                  done_q   <= 1'b1;
                  victim_q <= hand_q;
                  vd_q     <= cur_dirty;
                  hand_q   <= step(hand_q);
               end else begin
                  hand_q <= step(hand_q);
                  if (ph_q != PH_SIMPLE) begin
                     if (sweep_end) begin
                        cnt_q <= '0;
                        ph_q  <= (ph_q == PH_LOOK00) ? PH_LOOK01 : PH_LOOK00;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign hand         = hand_q;
   assign phase        = ph_q;
   assign busy         = (st_q == ST_SCAN);
   assign done         = done_q;
   assign victim       = victim_q;
   assign victim_dirty = vd_q;

   // R3: a free frame is returned on the next cycle without a scan
   p_free_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && any_free) |=> (done && !busy && !victim_dirty));
   // R7: hand sits just past the reported victim
   p_hand_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (hand == step(victim)));
   // R8: result pulse comes with the scan finished
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9: a request during a scan does not restart it
   p_busy_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !hit) |=> busy);
endmodule

// File: rtl/clock_victim_sel.sv
`timescale 1ns/1ps
module clock_victim_sel
   import cvs_pkg::*;
#(
   parameter int NUM_FRAMES = 8,
   localparam int IDX_W = $clog2(NUM_FRAMES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_enh,
   input  logic                  req,
   input  logic                  acc_valid,
   input  logic [IDX_W-1:0]      acc_frame,
   input  logic [NUM_FRAMES-1:0] occ,
   input  logic [NUM_FRAMES-1:0] dirty,
   output logic                  busy,
   output logic                  done,
   output logic [IDX_W-1:0]      victim,
   output logic                  victim_dirty
);
   localparam int MAX_BUSY = 4 * NUM_FRAMES;
   localparam int RUN_W    = $clog2(MAX_BUSY + 1) + 1;

   if (NUM_FRAMES < 2) begin : g_bad_frames
      $error("clock_victim_sel: NUM_FRAMES must be at least 2");
   end

   logic [NUM_FRAMES-1:0] use_w;
   logic                  clr_en_w, any_free_w;
   logic [IDX_W-1:0]      clr_idx_w, hand_w, free_idx_w;
   phase_e                phase_w;

   cvs_use_bits #(.NUM_FRAMES(NUM_FRAMES)) u_use (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (acc_valid),
      .set_idx (acc_frame),
      .clr_en  (clr_en_w),
      .clr_idx (clr_idx_w),
      .use_q   (use_w)
   );

   cvs_free_pick #(.NUM_FRAMES(NUM_FRAMES)) u_free (
      .hand     (hand_w),
      .occ      (occ),
      .any_free (any_free_w),
      .free_idx (free_idx_w)
   );

   cvs_scan_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .mode_enh     (mode_enh),
      .any_free     (any_free_w),
      .free_idx     (free_idx_w),
      .use_q        (use_w),
      .dirty        (dirty),
      .clr_en       (clr_en_w),
      .clr_idx      (clr_idx_w),
      .hand         (hand_w),
      .phase        (phase_w),
      .busy         (busy),
      .done         (done),
      .victim       (victim),
      .victim_dirty (victim_dirty)
   );

   // scan-length watch for the bound check
   logic [RUN_W-1:0] busy_run;
   always_ff @(posedge clk) begin
      if (!rst_n || !busy) busy_run <= '0;
      else if (busy_run != RUN_W'(MAX_BUSY)) busy_run <= busy_run + 1'b1;
   end

   // R8: a scan never outlasts four sweeps
   p_scan_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < RUN_W'(MAX_BUSY)));
   // R6: the (0,0) sweep leaves use bits untouched
   p_look00_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase_w == PH_LOOK00 && !acc_valid) |=> $stable(use_w));
   // R1: nothing pending out of reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done));
   // R8: result index stays inside the ring
   p_victim_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(victim) < NUM_FRAMES));
endmodule

// File: tb/clock_victim_sel_tb.sv
`timescale 1ns/1ps
module clock_victim_sel_tb;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_enh = 1'b0;
   logic       req = 1'b0;
   logic       acc_valid = 1'b0;
   logic [2:0] acc_frame = '0;
   logic [7:0] occ = 8'hFF;
   logic [7:0] dirty = 8'h00;
   logic       busy, done, victim_dirty;
   logic [2:0] victim;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   clock_victim_sel #(.NUM_FRAMES(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_enh(mode_enh), .req(req),
      .acc_valid(acc_valid), .acc_frame(acc_frame), .occ(occ), .dirty(dirty),
      .busy(busy), .done(done), .victim(victim), .victim_dirty(victim_dirty)
   );

   // {mode, touched, occ, dirty, exp_victim, exp_dirty, exp_busy_cycles}
   localparam logic [36:0] VEC [8] = '{
      {1'b0, 8'h01, 8'hFF, 8'h02, 3'd1, 1'b1, 8'd2},   // basic: skip used frame 0
      {1'b0, 8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, 8'd9},   // basic: full sweep of used frames
      {1'b1, 8'h00, 8'hFF, 8'h01, 3'd1, 1'b0, 8'd2},   // ranked: (0,0) beats (0,1)
      {1'b1, 8'h0F, 8'hFF, 8'hF0, 3'd4, 1'b1, 8'd13},  // ranked: (0,1) beats (1,0)
      {1'b1, 8'hFF, 8'hFF, 8'h0C, 3'd0, 1'b0, 8'd17},  // ranked: second (0,0) sweep
      {1'b1, 8'hFF, 8'hFF, 8'hFF, 3'd0, 1'b1, 8'd25},  // ranked: worst case
      {1'b0, 8'h00, 8'hDF, 8'h00, 3'd5, 1'b0, 8'd0},   // free frame, basic
      {1'b1, 8'h00, 8'h7F, 8'hFF, 3'd7, 1'b0, 8'd0}    // free frame, ranked, dirty ignored
   };

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = 1'b0; acc_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic touch(input logic [7:0] mask);
      for (int i = 0; i < N; i++) begin
         if (mask[i]) begin
            acc_valid = 1'b1;
            acc_frame = 3'(i);
            @(negedge clk);
         end
      end
      acc_valid = 1'b0;
   endtask

   task automatic request(output int v, output int vd, output int bcnt);
      bit got;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      bcnt = 0; got = 0; v = -1; vd = -1;
      for (int t = 0; t < 200 && !got; t++) begin
         if (done) begin
            got = 1; v = int'(victim); vd = int'(victim_dirty);
         end else begin
            if (busy) bcnt++;
            @(negedge clk);
         end
      end
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int v, vd, bc, dn, first_v;
      string tag;

      // R1: reset state
      do_reset();
      check_eq("R1 busy", int'(busy), 0);
      check_eq("R1 done", int'(done), 0);

      // vector table: each row from a fresh reset (R3 R4 R5 R6 R8)
      for (int r = 0; r < 8; r++) begin
         do_reset();
         touch(VEC[r][35:28]);
         mode_enh = VEC[r][36];
         occ      = VEC[r][27:20];
         dirty    = VEC[r][19:12];
         request(v, vd, bc);
         if (VEC[r][7:0] == 0)          tag = "R3";
         else if (!VEC[r][36])          tag = "R4";
         else if (VEC[r][7:0] > 2 * N)  tag = "R6";
         else                           tag = "R5";
         check_eq({tag, " victim"}, v, int'(VEC[r][11:9]));
         check_eq({tag, " victim_dirty"}, vd, int'(VEC[r][8]));
         check_eq("R8 busy cycles", bc, int'(VEC[r][7:0]));
      end

      // R2: accesses mark frames used; basic scan skips them
      do_reset();
      mode_enh = 1'b0; occ = 8'hFF; dirty = 8'h00;
      touch(8'h03);
      repeat (3) @(negedge clk);
      check_eq("R2 no spontaneous done", int'(done), 0);
      request(v, vd, bc);
      check_eq("R2 victim", v, 2);

      // R7 and R3: hand advance, free search from hand, wrap
      do_reset();
      mode_enh = 1'b0; occ = 8'hFF; dirty = 8'h00;
      request(v, vd, bc);
      check_eq("R7 first victim", v, 0);
      request(v, vd, bc);
      check_eq("R7 advanced victim", v, 1);
      occ = 8'h7F;
      request(v, vd, bc);
      check_eq("R3 free from hand", v, 7);
      check_eq("R3 free no busy", bc, 0);
      occ = 8'hFE;
      request(v, vd, bc);
      check_eq("R7 wrap victim", v, 0);
      occ = 8'hFF;
      request(v, vd, bc);
      check_eq("R7 after wrap", v, 1);

      // R4: the sweep clears use bits it passes
      do_reset();
      mode_enh = 1'b0; occ = 8'hFF; dirty = 8'h00;
      touch(8'hFF);
      request(v, vd, bc);
      check_eq("R4 sweep victim", v, 0);
      request(v, vd, bc);
      check_eq("R4 cleared bit victim", v, 1);
      check_eq("R4 cleared bit busy", bc, 1);

      // R9: a request during a scan is ignored
      do_reset();
      mode_enh = 1'b1; occ = 8'hFF; dirty = 8'hFF;
      touch(8'hFF);
      req = 1'b1; @(negedge clk); req = 1'b0;
      repeat (5) @(negedge clk);
      req = 1'b1; @(negedge clk); req = 1'b0;
      dn = 0; first_v = -1;
      for (int t = 0; t < 80; t++) begin
         if (done) begin
            dn++;
            if (first_v < 0) first_v = int'(victim);
         end
         @(negedge clk);
      end
      check_eq("R9 done count", dn, 1);
      check_eq("R9 victim", first_v, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule